// File: doc/BRIEF.md
# Particle Event Capture and Sparse Readout Sequencer

This block runs the front end of a multi-channel pulse-height measurement for one particle event at a time. While idle it keeps the channels' linear gates open and holds their discriminator latches in clear. The first rise of the combined discriminator signal opens a fixed capture window. When the window ends, the gates close and the per-channel trigger latches are strobed. The latched pattern is frozen inside the block. An external coincidence decision then either discards the event or lets the sequencer wait for the converters to finish.

For an accepted event, the sequencer raises an interrupt and presents one 24-bit word per triggered channel on a valid/ready bus, lowest channel first. Each word carries the high-gain pulse height. If the high-gain value is at full scale, the word carries the low-gain value instead and flags the switch. The last word of the event carries a token bit. The block goes back to idle only when the processor reports that it has finished with the event. The analog chain, the converters and the coincidence equations sit outside the block and appear as inputs.

Top module: `phseq_top`

## Requirements
- R1: During and after reset, and whenever idle, `gate_open`=1, `latch_clr`=1, `latch_strobe`=0, `irq`=0 and `out_valid`=0.
- R2: A high `lld_or` sampled while idle starts an event. `gate_open` stays 1 for exactly `WIN_CYC` cycles after the edge that sampled the trigger, with `latch_clr`=0. `latch_strobe` is then high for exactly one cycle, with `gate_open`=0.
- R3: `coinc_ok` is sampled in the cycle after the strobe. If it is 0, the sequencer returns to idle on the next cycle, and no interrupt and no word follow, even when `conv_done` is high.
- R4: If `coinc_ok` is 1, `gate_open` stays 0 and `irq` stays 0 until `conv_done` is seen. `irq` is 1 in the cycle after the edge that sampled `conv_done`.
- R5: Only channels whose `trig_lat` bit was 1 during the strobe cycle produce words. Words come in ascending channel order, and one word is consumed per cycle with `out_valid` and `out_ready` both 1. A word that is offered but not taken holds steady.
- R6: If a channel's high-gain value is 0x7FF, the word carries the low-gain value with bit 14 = 1. Otherwise it carries the high-gain value with bit 14 = 0. Bit 11 is 1 only when the low-gain value is also 0x7FF.
- R7: Word layout: bits 10:0 pulse height, bit 11 overflow, bits 13:12 zero, bit 14 gain flag, bits 18:15 channel number, bits 22:19 `chip_id`, bit 23 token.
- R8: Bit 23 is 1 on the final word of the event only. After that word is taken, `out_valid` is 0.
- R9: If coincidence passes but no channel latched, exactly one word is sent: token 1, pulse height 0, overflow 0, gain flag 0, channel 0, and `chip_id` in bits 22:19.
- R10: `irq` stays 1 from the first readout cycle until `rd_done` is seen after the token word has been taken. A `rd_done` that comes earlier is ignored. The cycle after `rd_done` is accepted, the sequencer is idle.
- R11: `lld_or` has no effect after the event has started. `trig_lat` changes after the strobe cycle have no effect on the words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lld_or | input | 1 | Wired-OR of all channel discriminators |
| trig_lat | input | NCH | Per-channel trigger latch outputs |
| coinc_ok | input | 1 | Coincidence decision, 1 = keep event |
| conv_done | input | 1 | All conversions complete |
| hi_ph | input | NCH*11 | High-gain pulse heights, channel i at bits 11*i+10:11*i |
| lo_ph | input | NCH*11 | Low-gain pulse heights, same packing |
| chip_id | input | 4 | Chip address placed in every word |
| gate_open | output | 1 | Linear gates open |
| latch_clr | output | 1 | Hold discriminator latches cleared |
| latch_strobe | output | 1 | One-cycle latch strobe at window end |
| irq | output | 1 | Event ready for the processor |
| out_valid | output | 1 | Readout word available |
| out_ready | input | 1 | Processor takes the word |
| out_word | output | 24 | Formatted readout word |
| rd_done | input | 1 | Processor finished reading the event |

## Verification
The bench builds the block with its default parameters: 16 channels and a 16-cycle window. With 16 channels the 4-bit channel field is fully used, so the all-channels event and the event with only channel 15 latched both exercise the highest address. The 16-cycle window is long enough to inject stray discriminator pulses in the middle of a capture. The stimulus draws full-scale values often enough that the high-gain, low-gain and double-overflow cases all occur inside the same event, and randomly stalled ready signals exercise the word-hold rule.

// File: rtl/phseq_pkg.sv
// Package: shared state encoding and readout word geometry for the
// particle event sequencer. Field positions are fixed by the reader.
package phseq_pkg;

    localparam int PH_W    = 11;   // pulse height field width
    localparam int CHAN_FW = 4;    // channel number field width
    localparam int CHIP_FW = 4;    // chip address field width
    localparam int WORD_W  = 24;   // readout word width
    localparam logic [PH_W-1:0] PH_FULL = '1;  // full-scale code

    typedef enum logic [2:0] {
        S_IDLE,    // gates open, latches held clear
        S_CAPT,    // capture window running
        S_STROBE,  // gates closed, latches strobed
        S_JUDGE,   // coincidence decision sampled
        S_CONV,    // waiting for conversions
        S_READ,    // words being handed out
        S_DONE     // waiting for processor release
    } seq_state_t;

    // Assemble one readout word from its fields.
    function automatic logic [WORD_W-1:0] make_word(
        input logic               token,
        input logic [CHIP_FW-1:0] chip,
        input logic [CHAN_FW-1:0] chan,
        input logic               low_gain,
        input logic               ovf,
        input logic [PH_W-1:0]    ph
    );
        return {token, chip, chan, low_gain, 2'b00, ovf, ph};
    endfunction

endpackage

// File: rtl/phseq_window.sv
// Capture window timer.
// Counts the cycles spent in the capture state and flags the last one.
// Assumes WIN_CYC >= 2 and that run is high for consecutive cycles.
module phseq_window #(
    parameter int WIN_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(WIN_CYC - 1);

    logic [CW-1:0] cnt;

    // Count while running, restart from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign last = run && (cnt == CNT_END);

    // R2: the counter never passes the end of the window.
    a_r2_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= CNT_END));

endmodule

// File: rtl/phseq_ctrl.sv
// Event sequencing state machine.
// Walks idle -> capture -> strobe -> judge -> conversion wait -> readout ->
// release wait, and drives gate, latch and interrupt lines from the state.
// Assumes the readout engine reports acceptance of the token word on last_acc.
module phseq_ctrl
    import phseq_pkg::*;
#(
    parameter int WIN_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lld_or,
    input  logic coinc_ok,
    input  logic conv_done,
    input  logic rd_done,
    input  logic last_acc,
    output logic gate_open,
    output logic latch_clr,
    output logic latch_strobe,
    output logic irq,
    output logic load,
    output logic read_en
);
    seq_state_t state, nxt;
    logic       win_last;

    phseq_window #(.WIN_CYC(WIN_CYC)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == S_CAPT),
        .last  (win_last)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (lld_or)    nxt = S_CAPT;
            S_CAPT:   if (win_last)  nxt = S_STROBE;
            S_STROBE:                nxt = S_JUDGE;
            S_JUDGE:  nxt = coinc_ok ? S_CONV : S_IDLE;
            S_CONV:   if (conv_done) nxt = S_READ;
            S_READ:   if (last_acc)  nxt = S_DONE;
            S_DONE:   if (rd_done)   nxt = S_IDLE;
            default:                 nxt = S_IDLE;
        endcase
    end

    // Output decode from the registered state.
    always_comb begin
        gate_open    = (state == S_IDLE) || (state == S_CAPT);
        latch_clr    = (state == S_IDLE);
        latch_strobe = (state == S_STROBE);
        irq          = (state == S_READ) || (state == S_DONE);
        load         = (state == S_STROBE);
        read_en      = (state == S_READ);
    end

    // R2: the strobe lasts one cycle and never overlaps open gates.
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        latch_strobe |=> !latch_strobe);
    a_r2_strobe_gates_shut: assert property (@(posedge clk) disable iff (!rst_n)
        latch_strobe |-> !gate_open);
    // R3: a rejected event leaves no interrupt behind.
    a_r3_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_JUDGE && !coinc_ok) |=> (gate_open && latch_clr && !irq));
    // R4: the interrupt rises only after conversion completes.
    a_r4_irq_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(conv_done));
    // R10: the interrupt drops only on a processor release.
    a_r10_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_done));

endmodule

// File: rtl/phseq_scan.sv
// Sparse readout engine.
// Freezes the trigger pattern on load, then offers one formatted word per
// latched channel, lowest number first, choosing high or low gain per channel.
// Assumes pulse-height inputs are stable while read_en is high and NCH <= 16.
module phseq_scan
    import phseq_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 read_en,
    input  logic [NCH-1:0]       trig_lat,
    input  logic [NCH*PH_W-1:0]  hi_ph,
    input  logic [NCH*PH_W-1:0]  lo_ph,
    input  logic [CHIP_FW-1:0]   chip_id,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    out_word,
    output logic                 last_acc
);
    logic [NCH-1:0]     pending;
    logic               sent_last;
    logic [NCH-1:0]     sel_oh;
    logic               found;
    logic [CHAN_FW-1:0] sel_chan;
    logic [PH_W-1:0]    sel_ph;
    logic               sel_low;
    logic               sel_ovf;
    logic               token;
    logic               accept;

    logic [PH_W-1:0] ch_ph  [NCH];
    logic            ch_low [NCH];
    logic            ch_ovf [NCH];

    // Per-channel gain choice: low gain only when high gain is saturated.
    for (genvar g = 0; g < NCH; g++) begin : g_gain
        logic [PH_W-1:0] hv, lv;
        assign hv = hi_ph[g*PH_W +: PH_W];
        assign lv = lo_ph[g*PH_W +: PH_W];
        always_comb begin
            ch_low[g] = (hv == PH_FULL);
            ch_ph[g]  = ch_low[g] ? lv : hv;
            ch_ovf[g] = ch_low[g] && (lv == PH_FULL);
        end
    end

    // Lowest pending channel and its word fields.
    always_comb begin
        found    = 1'b0;
        sel_oh   = '0;
        sel_chan = '0;
        sel_ph   = '0;
        sel_low  = 1'b0;
        sel_ovf  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (pending[i] && !found) begin
                found     = 1'b1;
                sel_oh[i] = 1'b1;
                sel_chan  = CHAN_FW'(i);
                sel_ph    = ch_ph[i];
                sel_low   = ch_low[i];
                sel_ovf   = ch_ovf[i];
            end
        end
    end

    assign token     = ((pending & ~sel_oh) == '0);
    assign out_valid = read_en && !sent_last;
    assign out_word  = make_word(token, chip_id, sel_chan, sel_low, sel_ovf, sel_ph);
    assign accept    = out_valid && out_ready;
    assign last_acc  = accept && token;

    // Pending mask: capture at strobe, retire one channel per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)      pending <= '0;
        else if (load)   pending <= trig_lat;
        else if (accept) pending <= pending & ~sel_oh;
    end

    // Marks that the token word has gone out for this event.
    always_ff @(posedge clk) begin
        if (!rst_n)        sent_last <= 1'b0;
        else if (load)     sent_last <= 1'b0;
        else if (last_acc) sent_last <= 1'b1;
    end

    // R5: an offered word is held until it is taken.
    a_r5_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
    // R5: each non-final accepted word retires exactly one channel.
    a_r5_one_per_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !token) |=> ($countones(pending) == $countones($past(pending)) - 1));
    // R6: a high-gain word is never at full scale.
    a_r6_gain_choice: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_word[14]) |-> (out_word[PH_W-1:0] != PH_FULL));
    // R8: nothing is offered after the token word is taken.
    a_r8_token_final: assert property (@(posedge clk) disable iff (!rst_n)
        last_acc |=> !out_valid);

endmodule

// File: rtl/phseq_top.sv
// Particle event capture and sparse readout sequencer, top level.
// Joins the event state machine with the sparse readout engine.
// Assumes NCH <= 16 so that channel numbers fit the 4-bit word field.
module phseq_top
    import phseq_pkg::*;
#(
    parameter int NCH     = 16,
    parameter int WIN_CYC = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lld_or,
    input  logic [NCH-1:0]      trig_lat,
    input  logic                coinc_ok,
    input  logic                conv_done,
    input  logic [NCH*11-1:0]   hi_ph,
    input  logic [NCH*11-1:0]   lo_ph,
    input  logic [3:0]          chip_id,
    output logic                gate_open,
    output logic                latch_clr,
    output logic                latch_strobe,
    output logic                irq,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [23:0]         out_word,
    input  logic                rd_done
);
    logic load, read_en, last_acc;

    phseq_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .lld_or       (lld_or),
        .coinc_ok     (coinc_ok),
        .conv_done    (conv_done),
        .rd_done      (rd_done),
        .last_acc     (last_acc),
        .gate_open    (gate_open),
        .latch_clr    (latch_clr),
        .latch_strobe (latch_strobe),
        .irq          (irq),
        .load         (load),
        .read_en      (read_en)
    );

    phseq_scan #(.NCH(NCH)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .read_en   (read_en),
        .trig_lat  (trig_lat),
        .hi_ph     (hi_ph),
        .lo_ph     (lo_ph),
        .chip_id   (chip_id),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .last_acc  (last_acc)
    );

    // R1: the readout bus is silent whenever the gates are open.
    a_r1_quiet_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |-> (!out_valid && !irq));

endmodule

// File: tb/phseq_top_bench.sv
// Bench for phseq_top: random events mixed with directed corner cases.
module phseq_top_bench;
    localparam int NCH     = 16;
    localparam int WIN_CYC = 16;
    localparam logic [10:0] FULL = 11'h7FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lld_or = 1'b0, coinc_ok = 1'b0, conv_done = 1'b0;
    logic out_ready = 1'b0, rd_done = 1'b0;
    logic [NCH-1:0] trig_lat = '0;
    logic [3:0] chip_id = 4'h0;
    logic [NCH*11-1:0] hi_ph, lo_ph;
    logic gate_open, latch_clr, latch_strobe, irq, out_valid;
    logic [23:0] out_word;

    logic [10:0] hi_a [NCH];
    logic [10:0] lo_a [NCH];

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // Behavioural pulse-height stub: pack per-channel values onto the buses.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            hi_ph[i*11 +: 11] = hi_a[i];
            lo_ph[i*11 +: 11] = lo_a[i];
        end
    end

    phseq_top #(.NCH(NCH), .WIN_CYC(WIN_CYC)) u_phseq_top (
        .clk(clk), .rst_n(rst_n), .lld_or(lld_or), .trig_lat(trig_lat),
        .coinc_ok(coinc_ok), .conv_done(conv_done), .hi_ph(hi_ph), .lo_ph(lo_ph),
        .chip_id(chip_id), .gate_open(gate_open), .latch_clr(latch_clr),
        .latch_strobe(latch_strobe), .irq(irq), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word), .rd_done(rd_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected word for one channel, from R6/R7.
    function automatic logic [23:0] exp_word(input int ch, input bit tok,
                                             input logic [3:0] chip);
        logic [10:0] ph;
        logic g, ov;
        g  = (hi_a[ch] == FULL);
        ph = g ? lo_a[ch] : hi_a[ch];
        ov = g && (lo_a[ch] == FULL);
        return {tok, chip, 4'(ch), g, 2'b00, ov, ph};
    endfunction

    function automatic logic [10:0] rand_ph();
        return (($urandom % 4) == 0) ? FULL : 11'($urandom % 2048);
    endfunction

    task automatic check_idle(input string req);
        chk(gate_open && latch_clr && !latch_strobe && !irq && !out_valid, req,
            "idle outputs", {gate_open, latch_clr, latch_strobe, irq, out_valid}, 5'b11000);
    endtask

    // One full event. Called at a negedge with the design idle.
    task automatic run_event(input logic [NCH-1:0] mask, input bit coinc,
                             input int conv_wait, input bit early_done);
        int cnt, got, nexp;
        int exp_ch [NCH];
        trig_lat = mask;
        chip_id  = 4'($urandom);
        lld_or   = 1'b1;
        @(posedge clk); @(negedge clk);
        lld_or = 1'b0;
        chk(!latch_clr, "R2", "latch clear released in window", latch_clr, 0);
        cnt = 0;
        while (gate_open && cnt < 100) begin
            cnt++;
            lld_or = 1'($urandom % 2);   // R11: stray triggers mid-window
            @(negedge clk);
        end
        lld_or = 1'b0;
        chk(cnt == WIN_CYC, "R2", "window length", cnt, WIN_CYC);
        chk(latch_strobe, "R2", "strobe at window end", latch_strobe, 1);
        coinc_ok = coinc;
        @(negedge clk);
        chk(!latch_strobe && !gate_open, "R2", "strobe single cycle",
            {latch_strobe, gate_open}, 0);
        trig_lat = ~mask;                 // R11: late latch changes ignored
        if (!coinc) begin
            @(negedge clk);
            coinc_ok = 1'b0;
            check_idle("R3");
            conv_done = 1'b1;
            repeat (3) begin
                @(negedge clk);
                chk(!irq && !out_valid, "R3", "no irq after reject", {irq, out_valid}, 0);
            end
            conv_done = 1'b0;
            return;
        end
        @(negedge clk);
        coinc_ok = 1'b0;
        chk(!irq && !gate_open, "R4", "waiting for conversion", {irq, gate_open}, 0);
        for (int w = 0; w < conv_wait; w++) begin
            @(negedge clk);
            chk(!irq && !out_valid, "R4", "no irq before conv_done", {irq, out_valid}, 0);
        end
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        chk(irq, "R4", "irq after conv_done", irq, 1);
        nexp = 0;
        for (int c = 0; c < NCH; c++) if (mask[c]) begin exp_ch[nexp] = c; nexp++; end
        got = 0;
        cnt = 0;
        rd_done = early_done;             // R10: early release ignored
        while (got < (nexp == 0 ? 1 : nexp) && cnt < 200) begin
            cnt++;
            out_ready = 1'($urandom % 2);
            if (out_valid && out_ready) begin
                if (nexp == 0)
                    chk(out_word == {1'b1, chip_id, 19'd0}, "R9", "empty event word",
                        out_word, {1'b1, chip_id, 19'd0});
                else
                    chk(out_word == exp_word(exp_ch[got], got == nexp - 1, chip_id),
                        "R5 R6 R7 R8", "readout word", out_word,
                        exp_word(exp_ch[got], got == nexp - 1, chip_id));
                got++;
            end
            chk(irq, "R10", "irq held during readout", irq, 1);
            @(negedge clk);
            rd_done = 1'b0;
        end
        out_ready = 1'b1;
        chk(!out_valid && irq, "R8", "bus quiet after token", {out_valid, irq}, 2'b01);
        repeat ($urandom % 4) begin
            @(negedge clk);
            chk(irq && !gate_open, "R10", "waiting for release", {irq, gate_open}, 2'b10);
        end
        out_ready = 1'b0;
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        check_idle("R10");
    endtask

    initial begin
        void'($urandom(32'd20417));
        for (int i = 0; i < NCH; i++) begin hi_a[i] = '0; lo_a[i] = '0; end
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // Directed: empty latch pattern with coincidence (R9).
        run_event('0, 1'b1, 2, 1'b0);
        // Directed: all channels, all high gains saturated, mixed low (R6).
        for (int i = 0; i < NCH; i++) begin
            hi_a[i] = FULL; lo_a[i] = (i % 2) ? FULL : 11'(i * 3);
        end
        run_event('1, 1'b1, 0, 1'b1);
        // Directed: only the top channel, then a rejected event (R3).
        hi_a[NCH-1] = 11'h123;
        run_event(16'h8000, 1'b1, 1, 1'b0);
        run_event(16'h00F0, 1'b0, 0, 1'b0);
        // Directed: idle with no trigger stays idle (R1).
        repeat (5) begin @(negedge clk); check_idle("R1"); end

        // Random events.
        for (int e = 0; e < 150; e++) begin
            for (int i = 0; i < NCH; i++) begin hi_a[i] = rand_ph(); lo_a[i] = rand_ph(); end
            run_event((($urandom % 8) == 0) ? '0 : NCH'($urandom),
                      ($urandom % 4) != 0, $urandom % 5, 1'($urandom % 2));
            repeat ($urandom % 3) @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule